// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Status Flag Byte

This block is the data-path core of a small 8-bit processor. Each cycle in which `op_valid` is high, it takes a 4-bit operation code, a register operand `opnd_a`, a second operand `opnd_b` and a bit index. It produces a result on `result` in the same cycle. At the next rising clock edge it updates a 5-flag status byte: negative, signed overflow, zero, nibble carry and carry. The stored carry acts as the carry-in for add-with-carry, subtract-with-borrow and the two rotates through carry.

The status byte is also an ordinary data location. When the surrounding core names it as the destination (`dest_is_status`), the unit suppresses the register-file write strobe `result_we`. An operation that affects no flag then writes its result straight into the byte. An operation that affects any flag throws its result away, and the byte takes only the new flags. For example, clearing the status byte only raises the zero flag. To read-modify-write the byte, the core feeds `status_q` back as `opnd_a`.

Top module: `alu_flag_unit`

## Requirements
- R1: `status_q` has bits 7..5 always 0, bit 4 = negative (N), bit 3 = overflow (OV), bit 2 = zero (Z), bit 1 = nibble carry (DC), bit 0 = carry (C). All five flags are 0 after reset.
- R2: ADD (op 0x0) gives a+b, and ADDC (op 0x1) gives a+b+C. C is set by a carry out of bit 7 and DC by a carry out of bit 3. All five flags are affected.
- R3: SUB (op 0x2) gives a-b, computed as a+~b+1, and SUBB (op 0x3) gives a+~b+C. C and DC are active-low borrows, where 1 means no borrow out of bit 7 or bit 3. All five flags are affected.
- R4: For ops 0x0..0x3, OV is 1 exactly when the signed two's-complement result falls outside -128..127.
- R5: For every operation that affects N and Z, N equals result bit 7 and Z is 1 exactly when the 8-bit result is zero.
- R6: AND (0x4), OR (0x5), XOR (0x6) and MOVF (0x8, result = a) affect only N and Z. OV, DC and C keep their values.
- R7: RLC (0xA) gives {a[6:0],C} and loads C with a[7]. RRC (0xB) gives {C,a[7:1]} and loads C with a[0]. Both affect only C, Z and N.
- R8: MOVB (0x9, result = b), SWAP (0xC, nibbles of a exchanged), BSET (0xD, a with bit `bit_sel` set), BCLR (0xE, a with bit `bit_sel` cleared) and PASS (0xF, result = a) leave every flag unchanged.
- R9: With `dest_is_status`=1, `result_we` is 0. A flag-affecting operation leaves in the status byte the same flags it would produce for a register destination, and its result is not stored.
- R10: CLR (0x7) gives result 0, sets Z and leaves N, OV, DC and C unchanged, for either destination.
- R11: With `dest_is_status`=1, an operation from R8 stores result bits 4..0 into the flag bits 4..0.
- R12: A cycle with `op_valid`=0 leaves `status_q` unchanged and `result_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Execute the presented operation this cycle |
| op_code | input | 4 | Operation select, encodings in R2..R10 |
| opnd_a | input | DATA_W | Register operand |
| opnd_b | input | DATA_W | Second operand (working register or literal) |
| bit_sel | input | $clog2(DATA_W) | Bit index for BSET/BCLR |
| dest_is_status | input | 1 | Destination is the status byte |
| result | output | DATA_W | Combinational operation result |
| result_we | output | 1 | Write strobe for a non-status destination |
| status_q | output | 8 | Status byte as read by software |

## Verification
The directed cases target the boundaries where a design is easy to get wrong. The case 0x80+0x80 needs carry, overflow and zero all at once. A design that takes DC from bit 4 would miss the carry at 0x0F+0x01. The cases 5-5 and 3-5 separate borrow polarity, because a design with a true-borrow C would report the opposite value. Writing ADD and CLR to the status byte exposes a design that stores the result instead of the flags, or that clears N, OV, DC and C on a clear. Constrained-random operations with a random destination then exercise carry chaining through ADDC, SUBB and the rotates. In these, a stale or wrong-polarity stored carry shows up in the result itself, in addition to the flags.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
   localparam int STAT_W = 8;
   localparam int FLAG_W = 5;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0, OP_ADDC = 4'h1, OP_SUB  = 4'h2, OP_SUBB = 4'h3,
      OP_AND  = 4'h4, OP_OR   = 4'h5, OP_XOR  = 4'h6, OP_CLR  = 4'h7,
      OP_MOVF = 4'h8, OP_MOVB = 4'h9, OP_RLC  = 4'hA, OP_RRC  = 4'hB,
      OP_SWAP = 4'hC, OP_BSET = 4'hD, OP_BCLR = 4'hE, OP_PASS = 4'hF
   } alu_op_e;

   // field order matches the status byte bits 4..0
   typedef struct packed {
      logic n;
      logic ov;
      logic z;
      logic dc;
      logic c;
   } flags_t;

   function automatic flags_t touch_mask(alu_op_e op);
      flags_t m;
      m = '0;
      case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: m = '{n:1'b1, ov:1'b1, z:1'b1, dc:1'b1, c:1'b1};
         OP_AND, OP_OR, OP_XOR, OP_MOVF:   m = '{n:1'b1, ov:1'b0, z:1'b1, dc:1'b0, c:1'b0};
         OP_CLR:                           m = '{n:1'b0, ov:1'b0, z:1'b1, dc:1'b0, c:1'b0};
         OP_RLC, OP_RRC:                   m = '{n:1'b1, ov:1'b0, z:1'b1, dc:1'b0, c:1'b1};
         default:                          m = '0;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/alu_flag_arith.sv
module alu_flag_arith #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              use_cin,
   input  logic              c_in,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,
   output logic              dc_out,
   output logic              ov_out
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic              cin_eff;
   logic [DATA_W:0]   full;
   logic [NIB_W:0]    low;

   always_comb begin
      b_eff   = sub ? ~b : b;
      cin_eff = use_cin ? c_in : sub;
      full    = {1'b0, a} + {1'b0, b_eff} + (DATA_W+1)'(cin_eff);
      low     = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + (NIB_W+1)'(cin_eff);
      sum     = full[DATA_W-1:0];
      c_out   = full[DATA_W];
      dc_out  = low[NIB_W];
      ov_out  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end
endmodule

// File: rtl/alu_flag_logic.sv
module alu_flag_logic
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int SEL_W = $clog2(DATA_W)
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              rot_c
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] sel_mask;

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign sel_mask[g] = (bit_sel == SEL_W'(g));
   end

   always_comb begin
      rot_c = 1'b0;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_CLR:  res = '0;
         OP_MOVB: res = b;
         OP_RLC: begin
            res   = {a[DATA_W-2:0], c_in};
            rot_c = a[DATA_W-1];
         end
         OP_RRC: begin
            res   = {c_in, a[DATA_W-1:1]};
            rot_c = a[0];
         end
         OP_SWAP: res = {a[HALF-1:0], a[DATA_W-1:HALF]};
         OP_BSET: res = a | sel_mask;
         OP_BCLR: res = a & ~sel_mask;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/alu_flag_status.sv
module alu_flag_status
   import alu_flag_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load_en,
   input  flags_t load_val,
   output flags_t flags_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_q <= '0;
      else if (load_en) flags_q <= load_val;
   end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int SEL_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic              dest_is_status,
   output logic [DATA_W-1:0] result,
   output logic              result_we,
   output logic [STAT_W-1:0] status_q
);
   localparam int MSB = DATA_W - 1;

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (DATA_W % 2 == 0) else $error("DATA_W must be even for nibble swap");
   end

   alu_op_e           op;
   flags_t            cur, fresh, mask, merged, next_val;
   logic [DATA_W-1:0] ar_sum, lg_res;
   logic              ar_c, ar_dc, ar_ov, lg_c;
   logic              is_arith;

   assign op       = alu_op_e'(op_code);
   assign is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBB);

   alu_flag_arith #(.DATA_W(DATA_W)) u_arith (
      .a      (opnd_a),
      .b      (opnd_b),
      .sub    ((op == OP_SUB) || (op == OP_SUBB)),
      .use_cin((op == OP_ADDC) || (op == OP_SUBB)),
      .c_in   (cur.c),
      .sum    (ar_sum),
      .c_out  (ar_c),
      .dc_out (ar_dc),
      .ov_out (ar_ov)
   );

   alu_flag_logic #(.DATA_W(DATA_W)) u_logic (
      .op     (op),
      .a      (opnd_a),
      .b      (opnd_b),
      .bit_sel(bit_sel),
      .c_in   (cur.c),
      .res    (lg_res),
      .rot_c  (lg_c)
   );

   always_comb begin
      result   = is_arith ? ar_sum : lg_res;
      fresh.n  = result[MSB];
      fresh.ov = ar_ov;
      fresh.z  = (result == '0);
      fresh.dc = ar_dc;
      fresh.c  = is_arith ? ar_c : lg_c;
      mask     = touch_mask(op);
      merged   = (fresh & mask) | (cur & ~mask);
      if (dest_is_status && (mask == '0)) next_val = flags_t'(result[FLAG_W-1:0]);
      else                                next_val = merged;
   end

   alu_flag_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (op_valid),
      .load_val(next_val),
      .flags_q (cur)
   );

   assign result_we = op_valid && !dest_is_status;
   assign status_q  = {{(STAT_W-FLAG_W){1'b0}}, cur};
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        op_code,
   input logic [DATA_W-1:0] opnd_a,
   input logic              dest_is_status,
   input logic [DATA_W-1:0] result,
   input logic              result_we,
   input logic [7:0]        status_q
);
   logic nz_op, quiet_op;
   assign nz_op = op_valid && (op_code <= 4'h6 || op_code == 4'h8 || op_code == 4'hA || op_code == 4'hB);
   assign quiet_op = op_valid && (op_code == 4'h9 || op_code >= 4'hC);

   a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[7:5] == 3'b000);

   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(status_q));

   a_r5_neg_follows: assert property (@(posedge clk) disable iff (!rst_n)
      nz_op |=> status_q[4] == $past(result[DATA_W-1]));

   a_r5_zero_follows: assert property (@(posedge clk) disable iff (!rst_n)
      nz_op |=> status_q[2] == ($past(result) == '0));

   a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dest_is_status && op_code == 4'h0) |=> status_q[2] == ($past(result) == '0));

   a_r10_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'h7) |=>
         status_q[2] && status_q[4:3] == $past(status_q[4:3]) && status_q[1:0] == $past(status_q[1:0]));

   a_r7_rlc_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'hA) |=> status_q[0] == $past(opnd_a[DATA_W-1]));

   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_op && !dest_is_status) |=> $stable(status_q));

   a_r12_we_low: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !result_we);
endmodule

bind alu_flag_unit alu_flag_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_valid      (op_valid),
   .op_code       (op_code),
   .opnd_a        (opnd_a),
   .dest_is_status(dest_is_status),
   .result        (result),
   .result_we     (result_we),
   .status_q      (status_q)
);

// File: tb/tb_alu_flag_unit.sv
`timescale 1ns/1ps
module tb_alu_flag_unit;
   localparam real CLK_P = 5.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_code = '0;
   logic [7:0] opnd_a = '0, opnd_b = '0;
   logic [2:0] bit_sel = '0;
   logic       dest_is_status = 1'b0;
   logic [7:0] result;
   logic       result_we;
   logic [7:0] status_q;

   int n_run = 0, n_fail = 0;
   logic [4:0] exp_st = '0;

   always #(CLK_P/2) clk = ~clk;

   alu_flag_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel),
      .dest_is_status(dest_is_status), .result(result),
      .result_we(result_we), .status_q(status_q)
   );

   // returns {next status[4:0], result[7:0]}
   function automatic logic [12:0] model(input logic [3:0] op, input logic [7:0] a, b,
                                         input logic [2:0] bs, input logic [4:0] st, input logic dest);
      int ai, bi, sa, sb, ci, t, s, dsum;
      logic [7:0] r;
      logic [4:0] fl, msk, nst;
      logic ov, dc, c;
      ai = int'(a); bi = int'(b); sa = int'($signed(a)); sb = int'($signed(b));
      ci = int'(st[0]); t = 0; s = 0; dsum = 0;
      ov = 1'b0; dc = 1'b0; c = 1'b0; msk = 5'b00000; r = a;
      case (op)
         4'h0: begin t = ai + bi;            s = sa + sb;            dsum = ai%16 + bi%16;            end
         4'h1: begin t = ai + bi + ci;       s = sa + sb + ci;       dsum = ai%16 + bi%16 + ci;       end
         4'h2: begin t = ai + 255 - bi + 1;  s = sa - sb;            dsum = ai%16 + 15 - bi%16 + 1;   end
         4'h3: begin t = ai + 255 - bi + ci; s = sa - sb - (1 - ci); dsum = ai%16 + 15 - bi%16 + ci;  end
         4'h4: begin r = a & b; msk = 5'b10100; end
         4'h5: begin r = a | b; msk = 5'b10100; end
         4'h6: begin r = a ^ b; msk = 5'b10100; end
         4'h7: begin r = 8'h00; msk = 5'b00100; end
         4'h8: begin r = a; msk = 5'b10100; end
         4'h9: r = b;
         4'hA: begin r = {a[6:0], st[0]}; c = a[7]; msk = 5'b10101; end
         4'hB: begin r = {st[0], a[7:1]}; c = a[0]; msk = 5'b10101; end
         4'hC: r = {a[3:0], a[7:4]};
         4'hD: r = a | (8'd1 << bs);
         4'hE: r = a & ~(8'd1 << bs);
         default: r = a;
      endcase
      if (op <= 4'h3) begin
         r = t[7:0]; c = (t > 255); dc = (dsum > 15); ov = (s > 127) || (s < -128);
         msk = 5'b11111;
      end
      fl  = {r[7], ov, (r == 8'h00), dc, c};
      nst = (fl & msk) | (st & ~msk);
      if (dest && msk == 5'b00000) nst = r[4:0];
      return {nst, r};
   endfunction

   function automatic string tag_of(input logic [3:0] op, input logic dest);
      if (dest) return (op == 4'h7) ? "R10" : ((op == 4'h9 || op >= 4'hC) ? "R11" : "R9");
      case (op)
         4'h0, 4'h1: return "R2";
         4'h2, 4'h3: return "R3";
         4'h7:       return "R10";
         4'hA, 4'hB: return "R7";
         4'h9, 4'hC, 4'hD, 4'hE, 4'hF: return "R8";
         default:    return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic [3:0] op, input logic [7:0] a, b, input logic [2:0] bs,
                        input logic dest, input string extra);
      logic [12:0] m;
      string tg;
      @(negedge clk);
      op_code = op; opnd_a = a; opnd_b = b; bit_sel = bs; dest_is_status = dest; op_valid = 1'b1;
      m = model(op, a, b, bs, exp_st, dest);
      tg = {tag_of(op, dest), extra};
      #1;
      check({tg, " result"}, 32'(result), 32'(m[7:0]));
      check({tg, " R9 we"}, 32'(result_we), 32'(!dest));
      @(negedge clk);
      op_valid = 1'b0;
      exp_st = m[12:8];
      check({tg, " R1 status"}, 32'(status_q), {27'd0, exp_st});
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h1F2E3D4C;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1 reset status", 32'(status_q), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 we idle", 32'(result_we), 32'h0);

      do_op(4'h0, 8'h80, 8'h80, 3'd0, 1'b0, " R4 R5 carry+ov+zero");
      do_op(4'h0, 8'h0F, 8'h01, 3'd0, 1'b0, " nibble carry");
      do_op(4'h0, 8'h7F, 8'h01, 3'd0, 1'b0, " R4 pos overflow");
      do_op(4'h2, 8'h05, 8'h05, 3'd0, 1'b0, " R5 no borrow zero");
      do_op(4'h2, 8'h03, 8'h05, 3'd0, 1'b0, " borrow");
      do_op(4'h2, 8'h80, 8'h01, 3'd0, 1'b0, " R4 neg overflow");
      do_op(4'h3, 8'h10, 8'h01, 3'd0, 1'b0, " chained borrow");
      do_op(4'h1, 8'hFF, 8'h00, 3'd0, 1'b0, " chained carry");
      do_op(4'hA, 8'h81, 8'h00, 3'd0, 1'b0, " rotate left");
      do_op(4'hB, 8'h01, 8'h00, 3'd0, 1'b0, " rotate right");
      do_op(4'h0, 8'h01, 8'hFF, 3'd0, 1'b1, " flags to status");
      do_op(4'h7, 8'h00, 8'h00, 3'd0, 1'b1, " clear status");
      do_op(4'h7, 8'h55, 8'h00, 3'd0, 1'b0, " clear register");
      do_op(4'hD, {3'b000, status_q[4:0]}, 8'h00, 3'd3, 1'b1, " bit set status");
      do_op(4'h9, 8'hFF, 8'hE5, 3'd0, 1'b1, " move to status");
      do_op(4'hC, 8'h3C, 8'h00, 3'd0, 1'b0, " swap keeps flags");
      do_op(4'h4, 8'hF0, 8'h0F, 3'd0, 1'b0, " and zero");

      // R12: idle cycles with busy inputs
      @(negedge clk);
      op_valid = 1'b0; op_code = 4'h7; opnd_a = 8'hAA; dest_is_status = 1'b1;
      repeat (2) @(negedge clk);
      check("R12 idle hold", 32'(status_q), {27'd0, exp_st});

      for (int i = 0; i < 600; i++) begin
         logic [3:0] op;
         logic       dst;
         logic [7:0] a;
         op  = 4'($urandom_range(0, 15));
         dst = ($urandom_range(0, 3) == 0);
         a   = 8'($urandom);
         if (dst && $urandom_range(0, 1) == 1) a = status_q;
         do_op(op, a, 8'($urandom), 3'($urandom), dst, " random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule